// File: doc/BRIEF.md
# Dual-Rail Ripple Adder with Completion Detection

This block adds two unsigned operands. Every operand bit, every internal carry and every result bit travels on a pair of wires: a true rail and a false rail. A pair with both rails low is the spacer, which means "no data yet". A pair with exactly one rail high carries a value. The adder waits until every bit of both operands holds a value. It then lets the carries settle and raises `done` only when every result pair has resolved. The moment `done` rises therefore follows the real length of the carry chains in the operands, not a fixed worst-case count.

The design is a clocked emulation of a self-timed circuit. On each clock edge, the carry resolution front moves one bit position. A bit that generates (both inputs 1) or kills (both inputs 0) resolves its carry on the first step without waiting for the carry below it. A bit that propagates must wait for the carry from the bit below. The block talks to both neighbours with a four-phase handshake:
- On the producer side, operands are presented and `in_ack` rises; the operands then return to spacer and `in_ack` falls.
- On the consumer side, `done` rises and `out_ack` rises in response; the outputs then return to spacer and `done` falls.

Top module: `dr_adder`

## Requirements
- R1: Each pair uses this encoding: 00 is spacer, 01 (false rail high) is logic 0, and 10 (true rail high) is logic 1. When `done` is high, the true rails of the sum and carry-out equal the (W+1)-bit sum of the two operands, and each false rail is the complement of its true rail.
- R2: An operation is accepted only when all pairs of both operands hold valid values. While any operand pair is spacer, `in_ack` stays low and `done` stays low.
- R3: An operand pair driven to 11 raises `err` in the same cycle, and an operation is not accepted while that pair is 11.
- R4: No output pair ever has both rails high. While an operation is evaluating, a rail that has gone high stays high until the consumer acknowledges.
- R5: Counting in clock edges after the acceptance edge, a carry resolves at step 1 if its bit is bit 0 or its bit generates or kills. Otherwise it resolves one step after the carry of the bit below. `done` rises at the step when the last carry resolves. So operands with no propagate bits finish in 1 step, and a full-width propagate chain takes W steps.
- R6: While `done` is high and `out_ack` is low, `done` and all output rails stay unchanged.
- R7: An edge that samples `done` and `out_ack` both high returns every output pair to spacer and drops `done`.
- R8: `in_ack` rises on the edge that accepts an operation and falls on the first edge that samples all operand pairs at spacer. A new operation is accepted only when `in_ack` is low, `out_ack` is low and no result is outstanding.
- R9: After reset, all output rails, `done` and `in_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock of the emulation |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_t | input | W | Operand A, true rails |
| a_f | input | W | Operand A, false rails |
| b_t | input | W | Operand B, true rails |
| b_f | input | W | Operand B, false rails |
| in_ack | output | 1 | Acknowledge to the producer |
| s_t | output | W | Sum, true rails |
| s_f | output | W | Sum, false rails |
| co_t | output | 1 | Carry-out, true rail |
| co_f | output | 1 | Carry-out, false rail |
| done | output | 1 | All result pairs resolved |
| out_ack | input | 1 | Acknowledge from the consumer |
| err | output | 1 | An operand pair is 11 |

## Verification
The assertions take for granted that the consumer raises `out_ack` only while `done` is high and keeps it high until `done` falls. They also take for granted that the producer holds its operands steady until `in_ack` rises. The stimulus follows both rules: each operation is one driver task that completes the whole four-phase cycle on both sides before the next one starts. The illegal and partial operand cases are driven only while the block is idle, and they return to spacer before normal traffic resumes.

// File: rtl/dr_adder.sv
`timescale 1ns/1ps
module dr_adder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  output logic         in_ack,
  output logic [W-1:0] s_t,
  output logic [W-1:0] s_f,
  output logic         co_t,
  output logic         co_f,
  output logic         done,
  input  logic         out_ack,
  output logic         err
);
  localparam int CW = $clog2(W + 1) + 1;

  logic         busy;
  logic [W-1:0] ra_t, ra_f, rb_t, rb_f;
  logic [W-1:0] c_t, c_f;
  logic [W-1:0] gen, kil, prp, ci_t, ci_f, nc_t, nc_f;
  logic         in_valid, in_spacer, accept;
  logic [CW-1:0] steps;

  assign in_valid  = (&(a_t ^ a_f)) & (&(b_t ^ b_f));
  assign in_spacer = ~|{a_t, a_f, b_t, b_f};
  assign err       = |{a_t & a_f, b_t & b_f};
  assign accept    = ~busy & ~in_ack & ~out_ack & in_valid;

  assign gen  = ra_t & rb_t;
  assign kil  = ra_f & rb_f;
  assign prp  = (ra_t & rb_f) | (ra_f & rb_t);
  assign ci_t = {c_t[W-2:0], 1'b0};
  assign ci_f = {c_f[W-2:0], busy};
  assign nc_t = gen | (prp & ci_t);
  assign nc_f = kil | (prp & ci_f);

  assign s_t  = (prp & ci_f) | ((gen | kil) & ci_t);
  assign s_f  = (prp & ci_t) | ((gen | kil) & ci_f);
  assign co_t = c_t[W-1];
  assign co_f = c_f[W-1];
  assign done = busy & (&(s_t | s_f)) & (co_t | co_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ra_t <= '0; ra_f <= '0; rb_t <= '0; rb_f <= '0;
      c_t  <= '0; c_f  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      ra_t <= a_t; ra_f <= a_f; rb_t <= b_t; rb_f <= b_f;
      c_t  <= '0; c_f  <= '0;
    end else if (done && out_ack) begin
      busy <= 1'b0;
      ra_t <= '0; ra_f <= '0; rb_t <= '0; rb_f <= '0;
      c_t  <= '0; c_f  <= '0;
    end else if (busy) begin
      c_t <= nc_t;
      c_f <= nc_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_ack <= 1'b0;
    else if (accept)    in_ack <= 1'b1;
    else if (in_spacer) in_ack <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              steps <= '0;
    else if (accept)         steps <= '0;
    else if (busy && !done)  steps <= steps + 1'b1;
  end

  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_t & s_f) == '0) && !(co_t && co_f)); // R4
  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && out_ack) |=> (((s_t & $past(s_t)) == $past(s_t)) && ((s_f & $past(s_f)) == $past(s_f)))); // R4
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_valid)); // R2
  AST_NO_ACCEPT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !$rose(in_ack)); // R3
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> (int'(steps) < W)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !out_ack) |=> (done && $stable(s_t) && $stable(s_f) && $stable(co_t))); // R6
  AST_RETURN_SPACER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_ack) |=> (!done && s_t == '0 && s_f == '0 && !co_t && !co_f)); // R7
endmodule

// File: tb/tb_dr_adder.sv
`timescale 1ns/1ps
module tb_dr_adder;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic out_ack = 1'b0;
  logic in_ack, co_t, co_f, done, err;
  logic [W-1:0] s_t, s_f;

  dr_adder #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .in_ack(in_ack), .s_t(s_t), .s_f(s_f), .co_t(co_t), .co_f(co_f),
    .done(done), .out_ack(out_ack), .err(err)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [W:0] total;
    int         steps;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int model_steps(input logic [W-1:0] a, input logic [W-1:0] b);
    int cur = 0;
    int worst = 0;
    for (int i = 0; i < W; i++) begin
      if (i == 0 || a[i] == b[i]) cur = 1;
      else cur = cur + 1;
      if (cur > worst) worst = cur;
    end
    return worst;
  endfunction

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    logic [W-1:0] hold;
    e.total = {1'b0, a} + {1'b0, b};
    e.steps = model_steps(a, b);
    exp_q.push_back(e);
    @(negedge clk);
    a_t = a; a_f = ~a; b_t = b; b_f = ~b;
    do @(negedge clk); while (!in_ack);
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    @(negedge clk);
    check(in_ack == 1'b0, "R8 in_ack falls after spacer", in_ack, 0);
    while (!done) @(negedge clk);
    hold = s_t;
    @(negedge clk);
    check(done && s_t == hold, "R6 result hold", {done, s_t}, {1'b1, hold});
    out_ack = 1'b1;
    @(negedge clk);
    check(!done && s_t == '0 && s_f == '0 && !co_t && !co_f, "R7 return to spacer",
          {done, co_t, co_f, s_t, s_f}, 0);
    out_ack = 1'b0;
  endtask

  always @(negedge clk) begin : monitor
    static logic prev_ack = 0, prev_done = 0;
    static bit counting = 0;
    static int cnt = 0;
    exp_t e;
    if (rst_n) begin
      if (in_ack && !prev_ack) begin
        counting = 1; cnt = 0;
      end else if (counting) cnt++;
      if (done && !prev_done) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          check({co_t, s_t} == e.total, "R1 sum value", {co_t, s_t}, e.total);
          check(s_f == ~s_t && co_f == ~co_t, "R1 false rails", {co_f, s_f}, {~co_t, ~s_t});
          check((s_t & s_f) == '0, "R4 rail exclusive", s_t & s_f, 0);
          check(cnt == e.steps, "R5 completion steps", cnt, e.steps);
        end
        counting = 0;
      end
      prev_ack = in_ack;
      prev_done = done;
    end
  end

  initial begin
    #(20 * 100000);
    check(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_t == '0 && s_f == '0 && !co_t && !co_f && !done && !in_ack, "R9 reset state",
          {done, in_ack, s_t, s_f}, 0);

    run_op(8'h00, 8'h00);
    run_op(8'hFF, 8'hFF);
    run_op(8'h55, 8'hAA);
    run_op(8'h01, 8'hFF);
    run_op(8'hF0, 8'h0F);
    run_op(8'h3C, 8'h3C);
    run_op(8'h81, 8'h7E);

    // R2: one pair of B still at spacer
    @(negedge clk);
    a_t = 8'h12; a_f = ~8'h12; b_t = 8'h34; b_f = ~8'h34;
    b_t[5] = 1'b0; b_f[5] = 1'b0;
    repeat (3) @(negedge clk);
    check(!in_ack && !done, "R2 partial operand not accepted", {in_ack, done}, 0);
    // R3: illegal pair
    b_t[5] = 1'b1; b_f[5] = 1'b1;
    #1;
    check(err == 1'b1, "R3 err on 11", err, 1);
    repeat (2) @(negedge clk);
    check(!in_ack && !done, "R3 illegal not accepted", {in_ack, done}, 0);
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    @(negedge clk);
    check(!err && !in_ack, "R3 err clears", {err, in_ack}, 0);

    for (int i = 0; i < 40; i++)
      run_op(8'(i * 37 + 11), 8'(i * 91 + 5));
    run_op(8'h80, 8'h80);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all results observed", exp_q.size(), 0);
    report();
  end
endmodule